// File: doc/BRIEF.md
# Data-Side Micro Translation Cache

This block is a four-entry, fully associative translation cache placed in front of a larger joint translation buffer. Each cycle it can accept a lookup made of a virtual page number, an address space identifier and the 12-bit page offset. One cycle later it answers with a registered result: either a hit carrying the physical address, or a miss. Every entry maps a single 4 KB page, so the offset is copied through untouched.

On the first miss it raises a refill request toward the joint buffer and holds that request until the response arrives. Lookups keep flowing every cycle while the request is outstanding. The returned mapping is written into a victim entry chosen by a two-level pseudo-LRU tree: the root bit picks the pair of entries not used most recently, and one bit per pair picks the entry within it. An invalidate-all pulse empties the cache when software rewrites the joint buffer.

Top module: `utlb_top`

## Requirements
- R1: Out of reset every entry is invalid, `resp_valid` and `miss_req` are low, and the first lookup reports a miss.
- R2: A lookup presented in cycle t gives `resp_valid` high in cycle t+1. `resp_hit` is high only when a valid entry matches both the page number and the space identifier. On a hit, `resp_pa` equals {entry PPN, lookup offset}, with the offset in bits [11:0].
- R3: An entry written with its global flag set matches a lookup of its page number whatever space identifier the lookup carries.
- R4: A lookup miss while no refill is outstanding raises `miss_req` in the next cycle. `miss_vpn` and `miss_asid` carry that lookup's page number and identifier, and all three stay unchanged until `refill_valid` is sampled.
- R5: While a refill is outstanding, lookups are still answered every cycle, and further misses do not alter `miss_vpn` or `miss_asid`.
- R6: `refill_valid` sampled with a request outstanding writes {`miss_vpn`, `miss_asid`, `refill_ppn`, `refill_global`} into the victim entry and drops `miss_req`. A lookup of that page in the next cycle hits. A lookup in the same cycle as the refill still sees the old contents.
- R7: The victim is chosen by three tree bits, all zero after reset. Root bit 0 selects entries {0,1} and 1 selects {2,3}. The selected pair's bit then picks its lower entry on 0 and its upper entry on 1. From reset, consecutive fills therefore land in entries 0, 2, 1, 3.
- R8: Every hit and every fill turns the tree bits away from the entry it touched: the root points at the other pair, and the pair bit points at the other entry of the pair.
- R9: When a hit and a fill occur in the same cycle, both tree updates take effect, and the hit's update is applied after the fill's.
- R10: `inval_all` clears every valid flag, zeroes the tree bits and cancels any outstanding refill within one cycle. A `refill_valid` in that cycle is discarded, and a lookup in that cycle reports a miss and raises no request.
- R11: `refill_valid` with no request outstanding changes no entry and no tree bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | Lookup present this cycle |
| lookup_vpn | input | VPN_W (20) | Virtual page number to translate |
| lookup_asid | input | ASID_W (8) | Address space identifier of the lookup |
| lookup_offset | input | OFF_W (12) | Page offset, passed through |
| resp_valid | output | 1 | Registered: a lookup was presented in the previous cycle |
| resp_hit | output | 1 | Registered: that lookup hit |
| resp_pa | output | PPN_W+OFF_W (36) | Physical address on a hit, zero on a miss |
| miss_req | output | 1 | Refill request outstanding |
| miss_vpn | output | VPN_W (20) | Page number being refilled |
| miss_asid | output | ASID_W (8) | Identifier of the page being refilled |
| refill_valid | input | 1 | Refill response from the joint buffer |
| refill_ppn | input | PPN_W (24) | Physical page number of the refill |
| refill_global | input | 1 | Refill entry ignores the identifier |
| inval_all | input | 1 | Invalidate every entry |

## Verification
Two cases share a cycle in this block. In the first, a hit lookup and a refill write land together and both move the tree bits. In the second, an invalidate arrives together with a refill response and a lookup. The bench provokes the first by holding a request open and then presenting a lookup of a resident page in the same cycle as `refill_valid`. It provokes the second by pulsing `inval_all` on a cycle that also carries a refill and a resident lookup. A bench-side model applies the fill update first and the hit update second, and gives the invalidate precedence over everything. Later fills then expose the victim order, and every response and request field is compared against that model. Random traffic over a small page and identifier set makes such collisions frequent.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int UTLB_WAYS  = 4;
  localparam int UTLB_IDX_W = 2;

  // tree bits: [0] pair select, [1] within pair {0,1}, [2] within pair {2,3}
  typedef logic [2:0] plru_t;

  function automatic plru_t plru_touch(plru_t bits, logic [UTLB_IDX_W-1:0] idx);
    plru_t r;
    r    = bits;
    r[0] = ~idx[1];
    if (idx[1]) r[2] = ~idx[0];
    else        r[1] = ~idx[0];
    return r;
  endfunction

  function automatic logic [UTLB_IDX_W-1:0] plru_pick(plru_t bits);
    return bits[0] ? {1'b1, bits[2]} : {1'b0, bits[1]};
  endfunction
endpackage

// File: rtl/utlb_cam.sv
module utlb_cam #(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PPN_W  = 24,
  parameter int WAYS   = 4,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [PPN_W-1:0]  hit_ppn,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic              wr_glb
);
  logic [WAYS-1:0]   valid_q;
  logic [WAYS-1:0]   glb_q;
  logic [VPN_W-1:0]  vpn_q  [WAYS];
  logic [ASID_W-1:0] asid_q [WAYS];
  logic [PPN_W-1:0]  ppn_q  [WAYS];
  logic [WAYS-1:0]   match;

  always_ff @(posedge clk) begin
    if (rst || clear)  valid_q <= '0;
    else if (wr_en)    valid_q[wr_idx] <= 1'b1;
  end

  // payload has no reset: only read behind a valid flag
  always_ff @(posedge clk) begin
    if (wr_en && !clear) begin
      vpn_q[wr_idx]  <= wr_vpn;
      asid_q[wr_idx] <= wr_asid;
      ppn_q[wr_idx]  <= wr_ppn;
      glb_q[wr_idx]  <= wr_glb;
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn) &&
                      (glb_q[g] || (asid_q[g] == lk_asid));
  end

  always_comb begin
    hit     = |match;
    hit_idx = '0;
    hit_ppn = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (match[i]) begin
        hit_idx = IDX_W'(i);
        hit_ppn = ppn_q[i];
      end
    end
  end

  // R6: a write that is not cancelled leaves its entry valid
  assert_fill_sets_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clear) |=> valid_q[$past(wr_idx)]);

  // R10: invalidate empties every entry
  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (rst)
    clear |=> (valid_q == '0));
endmodule

// File: rtl/utlb_plru.sv
module utlb_plru
  import utlb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clear,
  input  logic                  hit_en,
  input  logic [UTLB_IDX_W-1:0] hit_idx,
  input  logic                  fill_en,
  input  logic [UTLB_IDX_W-1:0] fill_idx,
  output logic [UTLB_IDX_W-1:0] victim
);
  plru_t bits_q, bits_d;

  always_comb begin
    bits_d = bits_q;
    if (fill_en) bits_d = plru_touch(bits_d, fill_idx);
    if (hit_en)  bits_d = plru_touch(bits_d, hit_idx);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) bits_q <= '0;
    else              bits_q <= bits_d;
  end

  assign victim = plru_pick(bits_q);

  // R8: the entry just hit is never the next victim
  assert_away_from_hit_R8: assert property (@(posedge clk) disable iff (rst)
    (hit_en && !clear) |=> (victim != $past(hit_idx)));
endmodule

// File: rtl/utlb_refill_ctl.sv
module utlb_refill_ctl #(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inval,
  input  logic              miss_ev,
  input  logic [VPN_W-1:0]  ev_vpn,
  input  logic [ASID_W-1:0] ev_asid,
  input  logic              refill_valid,
  output logic              pending,
  output logic [VPN_W-1:0]  req_vpn,
  output logic [ASID_W-1:0] req_asid,
  output logic              fire
);
  assign fire = pending && refill_valid && !inval;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      req_vpn  <= '0;
      req_asid <= '0;
    end else if (inval || fire) begin
      pending <= 1'b0;
    end else if (!pending && miss_ev) begin
      pending  <= 1'b1;
      req_vpn  <= ev_vpn;
      req_asid <= ev_asid;
    end
  end

  // R4: an open request holds its fields until answered or cancelled
  assert_req_stable_R4: assert property (@(posedge clk) disable iff (rst)
    (pending && !refill_valid && !inval) |=>
      (pending && $stable(req_vpn) && $stable(req_asid)));

  // R10: invalidate cancels any request
  assert_inval_drops_req_R10: assert property (@(posedge clk) disable iff (rst)
    inval |=> !pending);
endmodule

// File: rtl/utlb_top.sv
module utlb_top #(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PPN_W  = 24,
  parameter int OFF_W  = 12,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lookup_valid,
  input  logic [VPN_W-1:0]  lookup_vpn,
  input  logic [ASID_W-1:0] lookup_asid,
  input  logic [OFF_W-1:0]  lookup_offset,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [PA_W-1:0]   resp_pa,
  output logic              miss_req,
  output logic [VPN_W-1:0]  miss_vpn,
  output logic [ASID_W-1:0] miss_asid,
  input  logic              refill_valid,
  input  logic [PPN_W-1:0]  refill_ppn,
  input  logic              refill_global,
  input  logic              inval_all
);
  import utlb_pkg::*;

  logic                  cam_hit;
  logic [UTLB_IDX_W-1:0] cam_idx;
  logic [PPN_W-1:0]      cam_ppn;
  logic [UTLB_IDX_W-1:0] victim;
  logic                  eff_hit, miss_ev, fill;

  assign eff_hit = lookup_valid && cam_hit && !inval_all;
  assign miss_ev = lookup_valid && !cam_hit && !inval_all;

  utlb_cam #(.VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W), .WAYS(UTLB_WAYS)) u_cam (
    .clk(clk), .rst(rst), .clear(inval_all),
    .lk_vpn(lookup_vpn), .lk_asid(lookup_asid),
    .hit(cam_hit), .hit_idx(cam_idx), .hit_ppn(cam_ppn),
    .wr_en(fill), .wr_idx(victim), .wr_vpn(miss_vpn), .wr_asid(miss_asid),
    .wr_ppn(refill_ppn), .wr_glb(refill_global)
  );

  utlb_plru u_plru (
    .clk(clk), .rst(rst), .clear(inval_all),
    .hit_en(eff_hit), .hit_idx(cam_idx),
    .fill_en(fill), .fill_idx(victim),
    .victim(victim)
  );

  utlb_refill_ctl #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_ctl (
    .clk(clk), .rst(rst), .inval(inval_all),
    .miss_ev(miss_ev), .ev_vpn(lookup_vpn), .ev_asid(lookup_asid),
    .refill_valid(refill_valid),
    .pending(miss_req), .req_vpn(miss_vpn), .req_asid(miss_asid),
    .fire(fill)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_pa    <= '0;
    end else begin
      resp_valid <= lookup_valid;
      resp_hit   <= eff_hit;
      resp_pa    <= eff_hit ? {cam_ppn, lookup_offset} : '0;
    end
  end

  // R2: a response follows every lookup by exactly one cycle
  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    lookup_valid |=> resp_valid);
endmodule

// File: tb/tb_utlb_top.sv
module tb_utlb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lookup_valid = 1'b0;
  logic [19:0] lookup_vpn = '0;
  logic [7:0]  lookup_asid = '0;
  logic [11:0] lookup_offset = '0;
  logic        resp_valid, resp_hit, miss_req;
  logic [35:0] resp_pa;
  logic [19:0] miss_vpn;
  logic [7:0]  miss_asid;
  logic        refill_valid = 1'b0;
  logic [23:0] refill_ppn = '0;
  logic        refill_global = 1'b0;
  logic        inval_all = 1'b0;

  always #5 clk = ~clk;

  utlb_top dut (
    .clk(clk), .rst(rst), .lookup_valid(lookup_valid), .lookup_vpn(lookup_vpn),
    .lookup_asid(lookup_asid), .lookup_offset(lookup_offset),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_pa(resp_pa),
    .miss_req(miss_req), .miss_vpn(miss_vpn), .miss_asid(miss_asid),
    .refill_valid(refill_valid), .refill_ppn(refill_ppn),
    .refill_global(refill_global), .inval_all(inval_all)
  );

  int errs = 0;
  int checks = 0;

  // bench model
  logic        m_val  [4];
  logic        m_glb  [4];
  logic [19:0] m_vpn  [4];
  logic [7:0]  m_asid [4];
  logic [23:0] m_ppn  [4];
  logic [2:0]  m_tree;
  logic        m_pend;
  logic [19:0] m_mvpn;
  logic [7:0]  m_masid;
  logic        e_rv, e_hit;
  logic [35:0] e_pa;

  function automatic logic [23:0] jt_ppn(logic [19:0] v);
    return 24'(v) * 24'd7 + 24'h3A0;
  endfunction
  function automatic logic jt_glb(logic [19:0] v);
    return v[2];
  endfunction

  // victim per R7
  function automatic int pick(logic [2:0] t);
    if (t[0] == 1'b0) return t[1] ? 1 : 0;
    return t[2] ? 3 : 2;
  endfunction
  // turn away per R8
  function automatic logic [2:0] away(logic [2:0] t, int e);
    logic [2:0] r = t;
    case (e)
      0: begin r[0] = 1'b1; r[1] = 1'b1; end
      1: begin r[0] = 1'b1; r[1] = 1'b0; end
      2: begin r[0] = 1'b0; r[2] = 1'b1; end
      default: begin r[0] = 1'b0; r[2] = 1'b0; end
    endcase
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) m_val[i] = 1'b0;
    m_tree = '0; m_pend = 1'b0; m_mvpn = '0; m_masid = '0;
  endtask

  task automatic step(input logic lv, input logic [19:0] v, input logic [7:0] a,
                      input logic [11:0] off, input logic rv, input logic inv,
                      input string tag);
    logic h;
    int hi, vic;
    logic old_pend;
    @(negedge clk);
    lookup_valid = lv; lookup_vpn = v; lookup_asid = a; lookup_offset = off;
    refill_valid = rv; refill_ppn = jt_ppn(m_mvpn); refill_global = jt_glb(m_mvpn);
    inval_all = inv;
    @(posedge clk);
    #1;
    h = 1'b0; hi = 0;
    for (int i = 0; i < 4; i++)
      if (m_val[i] && m_vpn[i] == v && (m_glb[i] || m_asid[i] == a)) begin h = 1'b1; hi = i; end
    e_rv  = lv;
    e_hit = lv && h && !inv;
    e_pa  = {m_ppn[hi], off};
    old_pend = m_pend;
    vic = pick(m_tree);
    if (inv) begin
      for (int i = 0; i < 4; i++) m_val[i] = 1'b0;
      m_tree = '0; m_pend = 1'b0;
    end else begin
      if (rv && old_pend) begin
        m_val[vic] = 1'b1; m_vpn[vic] = m_mvpn; m_asid[vic] = m_masid;
        m_ppn[vic] = jt_ppn(m_mvpn); m_glb[vic] = jt_glb(m_mvpn);
        m_tree = away(m_tree, vic);
        m_pend = 1'b0;
      end
      if (e_hit) m_tree = away(m_tree, hi);
      if (!old_pend && lv && !h) begin
        m_pend = 1'b1; m_mvpn = v; m_masid = a;
      end
    end
    chk({tag, " resp_valid"}, 64'(resp_valid), 64'(e_rv));
    if (e_rv) chk({tag, " resp_hit"}, 64'(resp_hit), 64'(e_hit));
    if (e_hit) chk({tag, " resp_pa"}, 64'(resp_pa), 64'(e_pa));
    chk({tag, " miss_req"}, 64'(miss_req), 64'(m_pend));
    if (m_pend) begin
      chk({tag, " miss_vpn"}, 64'(miss_vpn), 64'(m_mvpn));
      chk({tag, " miss_asid"}, 64'(miss_asid), 64'(m_masid));
    end
  endtask

  task automatic lk(input logic [19:0] v, input logic [7:0] a, input string tag);
    step(1'b1, v, a, 12'(v * 20'd13), 1'b0, 1'b0, tag);
  endtask
  task automatic answer(input string tag);
    step(1'b0, '0, '0, '0, 1'b1, 1'b0, tag);
  endtask
  task automatic fill(input logic [19:0] v, input logic [7:0] a, input string tag);
    lk(v, a, tag);
    answer(tag);
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    logic [31:0] r;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 resp_valid after reset", 64'(resp_valid), 64'd0);
    chk("R1 miss_req after reset", 64'(miss_req), 64'd0);

    // R1/R4: first lookup misses and opens a request
    lk(20'h100, 8'd1, "R1");
    // R5: lookups keep answering, request fields frozen
    lk(20'h101, 8'd1, "R5");
    lk(20'h102, 8'd2, "R5");
    step(1'b0, '0, '0, '0, 1'b0, 1'b0, "R4");
    // R6: answer, then hit next cycle; same-cycle lookup sees old state
    step(1'b1, 20'h100, 8'd1, 12'h5A5, 1'b1, 1'b0, "R6");
    lk(20'h100, 8'd1, "R6");
    // R3: global page (bit 2 set) matches any identifier
    fill(20'h104, 8'd1, "R3");
    lk(20'h104, 8'd9, "R3");
    lk(20'h100, 8'd9, "R2");
    // R7: fill order and eviction
    fill(20'h101, 8'd1, "R7");
    fill(20'h102, 8'd1, "R7");
    fill(20'h103, 8'd1, "R7");
    for (int i = 0; i < 5; i++) lk(20'h100 + 20'(i), 8'd1, "R7");
    // R8: hits steer the victim
    lk(20'h102, 8'd1, "R8");
    fill(20'h105, 8'd1, "R8");
    for (int i = 0; i < 6; i++) lk(20'h100 + 20'(i), 8'd1, "R8");
    // R9: hit and fill in the same cycle
    lk(20'h106, 8'd1, "R9");
    step(1'b1, 20'h105, 8'd1, 12'h0F0, 1'b1, 1'b0, "R9");
    fill(20'h107, 8'd1, "R9");
    for (int i = 0; i < 8; i++) lk(20'h100 + 20'(i), 8'd1, "R9");
    // R10: invalidate with refill and lookup in the same cycle
    lk(20'h10A, 8'd1, "R10");
    step(1'b1, 20'h107, 8'd1, 12'h111, 1'b1, 1'b1, "R10");
    step(1'b0, '0, '0, '0, 1'b0, 1'b0, "R10");
    for (int i = 0; i < 8; i++) lk(20'h100 + 20'(i), 8'd1, "R10");
    answer("R10");
    // R11: stray refill has no effect
    answer("R11");
    lk(20'h10A, 8'd1, "R11");
    answer("R11");
    lk(20'h10A, 8'd1, "R11");

    // random traffic
    seed = 32'h5EED_0001;
    r = $urandom(seed);
    for (int n = 0; n < 4000; n++) begin
      logic lv, rv, inv;
      r   = $urandom;
      lv  = (r[3:0] < 4'd11);
      rv  = (r[7:4] < 4'd5);
      inv = (r[15:8] < 8'd3);
      step(lv, 20'h100 + 20'(r[18:16]), 8'(r[19]) + 8'd1, r[31:20], rv, inv, "R2");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule